// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive engine of a descriptor-driven network controller. Frames arrive as a byte stream, one byte per accepted beat, with a last-byte marker and a CRC-error flag on the final beat. The block places each frame in the memory buffer named by the current entry of a descriptor ring, then writes a completion status back into that entry. It then moves on to the next entry, and returns to the ring base after the entry marked end-of-ring.

Each descriptor is 16 bytes long. Word 0 holds the status and word 2 holds the buffer address. The ring base is 256-byte aligned. Software arms an entry by setting the ownership bit together with the buffer size in the low 13 bits. The block gives the entry back by writing the status with ownership cleared. If the current entry is not owned by the hardware when a frame begins, the block drops the frame and counts it as missed.

The memory port takes one access per cycle. Read data returns on the cycle after the read strobe. Writes are either single bytes with a one-hot byte enable or full status words.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the block makes no memory access, holds `in_ready` low, reports zero on `missed_cnt`, and uses the entry at the ring base, which is `ring_base` with its low 8 bits taken as zero.
- R2: When a frame's first beat is offered while the block is idle, the block reads the status word at the entry address (base + 16 × index). If that word has bit 31 (ownership) set, it then reads the buffer address from entry address + 8.
- R3: If the status word has bit 31 clear, the block consumes the whole frame without any memory write and increments `missed_cnt` by one. The entry is not advanced, so the next frame checks the same entry again.
- R4: Byte k of a frame (k counted from 0) is written to buffer address + k. `mem_be` is one-hot at bit position `addr[1:0]`, and the byte is replicated on all four lanes of `mem_wdata`.
- R5: Only the first N bytes are stored, where N is the size in status bits 12:0. Any byte beyond N produces no write and sets bit 22 (overlong) in the written-back status.
- R6: On completion the block writes the status word at the entry address with all byte enables set. Bits 12:0 hold the stored byte count, which includes the CRC bytes carried in the stream. Bit 31 is clear, bits 29 and 28 (first and last segment) are set, and bit 30 is copied from the armed word.
- R7: Bit 20 (runt) is set when the frame had fewer than 64 bytes in total.
- R8: Bit 19 (CRC error) equals `in_crc_err` as sampled on the frame's last beat.
- R9: Bit 21 is set exactly when at least one of bits 19, 20 or 22 is set. All other status bits are zero.
- R10: After a write-back the next entry is index + 1. If the completed entry had bit 30 (end-of-ring) set, the next entry is the ring base.
- R11: `mem_rd` and `mem_wr` are never high together. `in_ready` is high only while a frame's bytes are being taken, and never in a cycle with `mem_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Ring base address (low 8 bits ignored) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| in_ready | output | 1 | Stream byte accepted on this edge when valid |
| mem_rd | output | 1 | Word read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| missed_cnt | output | MISS_W | Count of frames dropped for lack of an owned entry |

## Verification
The bench sweeps frame lengths around the edges that matter: a single byte, 63/64/65 around the runt limit, and size−1, size and size+1 around a buffer size of 80. It also alternates the CRC flag. A length counter that is off by one would misreport the runt bit or the overlong bit, or would write one byte past the sentinel placed after each buffer. The bench runs several laps of a four-entry ring, so a wrong wrap would read the wrong entry address. It then offers a frame to an entry that software has not re-armed: a design that ignored ownership would overwrite the stale status, and one that advanced the index on a drop would put the next frame in the wrong entry.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_BUF, ST_DATA, ST_DROP, ST_WB
  } rxr_state_e;

  localparam int OWN_B   = 31;
  localparam int EOR_B   = 30;
  localparam int FS_B    = 29;
  localparam int LS_B    = 28;
  localparam int LONG_B  = 22;
  localparam int ESUM_B  = 21;
  localparam int RUNT_B  = 20;
  localparam int CRC_B   = 19;
  localparam int LEN_W   = 13;
  localparam int MIN_FRM = 64;
endpackage

// File: rtl/rxr_len_track.sv
module rxr_len_track
  import rxr_pkg::*;
#(
  parameter int MIN_LEN = MIN_FRM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             beat,
  input  logic [LEN_W-1:0] size,
  output logic [LEN_W-1:0] stored,
  output logic             store_ok,
  output logic             overlong,
  output logic             runt
);
  localparam int TOT_W = $clog2(MIN_LEN) + 1;

  logic [LEN_W-1:0] stored_d;
  logic [TOT_W-1:0] tot_q, tot_d;
  logic             over_d;

  assign store_ok = (stored < size);
  assign runt     = (tot_q < TOT_W'(MIN_LEN));

  always_comb begin
    stored_d = stored;
    tot_d    = tot_q;
    over_d   = overlong;
    if (clr) begin
      stored_d = '0;
      tot_d    = '0;
      over_d   = 1'b0;
    end else if (beat) begin
      if (store_ok) stored_d = stored + 1'b1;
      else          over_d   = 1'b1;
      if (runt)     tot_d    = tot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored   <= '0;
      tot_q    <= '0;
      overlong <= 1'b0;
    end else if (clr || beat) begin
      stored   <= stored_d;
      tot_q    <= tot_d;
      overlong <= over_d;
    end
  end

  AST_STORED_LE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> stored <= size); // R5
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxr_pkg::*;
(
  input  logic             eor,
  input  logic [LEN_W-1:0] stored,
  input  logic             overlong,
  input  logic             runt,
  input  logic             crc_err,
  output logic [31:0]      status
);
  always_comb begin
    status             = '0;
    status[LEN_W-1:0]  = stored;
    status[OWN_B]      = 1'b0;
    status[EOR_B]      = eor;
    status[FS_B]       = 1'b1;
    status[LS_B]       = 1'b1;
    status[LONG_B]     = overlong;
    status[RUNT_B]     = runt;
    status[CRC_B]      = crc_err;
    status[ESUM_B]     = overlong | runt | crc_err;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_crc_err,
  output logic              in_ready,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_cnt
);
  localparam int DESC_SH = 4;
  localparam int ALIGN   = 8;

  rxr_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  size_q;
  logic              eor_q, crc_q;
  logic [ADDR_W-1:0] buf_q;
  logic [MISS_W-1:0] miss_d;
  logic              stat_en, buf_en, crc_en;
  logic              clr, beat, store_ok, overlong, runt;
  logic [LEN_W-1:0]  stored;
  logic [31:0]       wb_status;
  logic [ADDR_W-1:0] desc_addr;

  assign desc_addr = {ring_base[ADDR_W-1:ALIGN], ALIGN'(0)}
                   + ADDR_W'({idx_q, DESC_SH'(0)});

  rxr_len_track i_len (
    .clk(clk), .rst_n(rst_n), .clr(clr), .beat(beat), .size(size_q),
    .stored(stored), .store_ok(store_ok), .overlong(overlong), .runt(runt)
  );

  rxr_status_fmt i_fmt (
    .eor(eor_q), .stored(stored), .overlong(overlong), .runt(runt),
    .crc_err(crc_q), .status(wb_status)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    miss_d    = missed_cnt;
    stat_en   = 1'b0;
    buf_en    = 1'b0;
    crc_en    = 1'b0;
    clr       = 1'b0;
    beat      = 1'b0;
    in_ready  = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = 4'h0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          mem_rd  = 1'b1;
          state_d = ST_STAT;
        end
      end
      ST_STAT: begin
        stat_en = 1'b1;
        clr     = 1'b1;
        if (mem_rdata[OWN_B]) begin
          mem_rd   = 1'b1;
          mem_addr = desc_addr + ADDR_W'(8);
          state_d  = ST_BUF;
        end else begin
          miss_d  = missed_cnt + 1'b1;
          state_d = ST_DROP;
        end
      end
      ST_BUF: begin
        buf_en  = 1'b1;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        in_ready = 1'b1;
        beat     = in_valid;
        if (in_valid && store_ok) begin
          mem_wr    = 1'b1;
          mem_addr  = buf_q + ADDR_W'(stored);
          mem_be    = 4'b0001 << mem_addr[1:0];
          mem_wdata = {4{in_data}};
        end
        if (in_valid && in_last) begin
          crc_en  = 1'b1;
          state_d = ST_WB;
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) state_d = ST_IDLE;
      end
      ST_WB: begin
        mem_wr    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = wb_status;
        idx_d     = eor_q ? '0 : idx_q + 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      missed_cnt <= '0;
      size_q     <= '0;
      eor_q      <= 1'b0;
      buf_q      <= '0;
      crc_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      missed_cnt <= miss_d;
      if (stat_en) begin
        size_q <= mem_rdata[LEN_W-1:0];
        eor_q  <= mem_rdata[EOR_B];
      end
      if (buf_en) buf_q <= mem_rdata;
      if (crc_en) crc_q <= in_crc_err;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
  AST_READY_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_rd); // R11
  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_be == 4'hF) |-> (!mem_wdata[OWN_B] && mem_wdata[FS_B] && mem_wdata[LS_B])); // R6
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed_cnt) |-> missed_cnt == $past(missed_cnt) + 1'b1); // R3
  AST_DROP_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_wr); // R3
  AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_be != 4'hF) |-> $onehot0(mem_be) && mem_be != 4'h0); // R4
endmodule

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  localparam int RING  = 4;
  localparam int BSIZE = 80;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, in_crc_err, in_ready;
  logic [7:0]  in_data;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [15:0] missed_cnt;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [0:4095];
  int wr_cnt = 0;
  int rd_n = 0;
  logic [31:0] rd_log [0:1];

  always #2.5 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE | 32'h0000_0037),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_err(in_crc_err), .in_ready(in_ready),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .missed_cnt(missed_cnt)
  );

  function automatic logic [31:0] rdw(input int a);
    rdw = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= rdw(int'(mem_addr[11:0]) & ~3);
      if (rd_n < 2) rd_log[rd_n] = mem_addr;
      rd_n = rd_n + 1;
    end
    if (mem_wr) begin
      wr_cnt = wr_cnt + 1;
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[(int'(mem_addr[11:0]) & ~3) + l] = mem_wdata[8*l +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrw(input int a, input logic [31:0] v);
    for (int l = 0; l < 4; l++) mem[a+l] = v[8*l +: 8];
  endtask

  task automatic arm(input int i);
    int d = int'(BASE) + 16*i;
    wrw(d, 32'h8000_0000 | BSIZE | ((i == RING-1) ? 32'h4000_0000 : 0));
    wrw(d + 8, 32'h400 + 32'h100*i);
    for (int k = 0; k < 256; k++) mem[32'h400 + 256*i + k] = 8'hEE;
  endtask

  function automatic int flen(input int n);
    case (n)
      0: flen = 1;   1: flen = 63;  2: flen = 64;  3: flen = 65;
      4: flen = 79;  5: flen = 80;  6: flen = 81;  7: flen = 120;
      8: flen = 2;   9: flen = 100; 10: flen = 64; default: flen = 4;
    endcase
  endfunction

  task automatic send(input int n, input int len, input bit crc);
    rd_n = 0;
    for (int k = 0; k < len; k++) begin
      in_valid   = 1'b1;
      in_data    = 8'((n*7 + k) & 8'hFF);
      in_last    = (k == len-1);
      in_crc_err = crc && (k == len-1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_ok(input int n, input int i);
    int len = flen(n);
    bit crc = (n % 3 == 1);
    int st  = (len < BSIZE) ? len : BSIZE;
    bit ov  = (len > BSIZE), rn = (len < 64);
    logic [31:0] exp;
    int d = int'(BASE) + 16*i;
    int bad = 0;
    send(n, len, crc);
    exp = 32'(st) | 32'h3000_0000 | ((i == RING-1) ? 32'h4000_0000 : 0)
        | (ov ? 32'h0040_0000 : 0) | (rn ? 32'h0010_0000 : 0)
        | (crc ? 32'h0008_0000 : 0) | ((ov|rn|crc) ? 32'h0020_0000 : 0);
    chk(rdw(d) == exp, "R6 R7 R8 R9 status", rdw(d), exp);
    chk(rd_log[0] == 32'(d), "R2 R10 entry read", rd_log[0], 32'(d));
    chk(rd_log[1] == 32'(d+8), "R2 buffer ptr read", rd_log[1], 32'(d+8));
    for (int k = 0; k < st; k++)
      if (mem[32'h400 + 256*i + k] != 8'((n*7 + k) & 8'hFF)) bad++;
    chk(bad == 0, "R4 bytes", 32'(bad), 0);
    chk(mem[32'h400 + 256*i + st] == 8'hEE, "R5 no write past size",
        32'(mem[32'h400 + 256*i + st]), 32'hEE);
    chk(in_ready == 1'b0, "R11 ready low when idle", 32'(in_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    in_valid = 0; in_last = 0; in_crc_err = 0; in_data = 0;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_rd && !mem_wr && !in_ready, "R1 quiet after reset",
        {29'd0, mem_rd, mem_wr, in_ready}, 0);
    chk(missed_cnt == 0, "R1 missed zero", 32'(missed_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < RING; i++) arm(i);
      for (int i = 0; i < RING; i++) frame_ok(4*r + i, i);
    end
    w0 = wr_cnt;
    send(50, 20, 1'b0);
    chk(missed_cnt == 1, "R3 missed count", 32'(missed_cnt), 1);
    chk(wr_cnt == w0, "R3 no write on drop", 32'(wr_cnt), 32'(w0));
    chk(rd_n == 1 && rd_log[0] == BASE, "R3 single status read at base",
        rd_log[0], BASE);
    send(51, 3, 1'b0);
    chk(missed_cnt == 2, "R3 second drop counted", 32'(missed_cnt), 2);
    arm(0);
    frame_ok(0, 0);
    chk(missed_cnt == 2, "R3 no miss when owned", 32'(missed_cnt), 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule